// File: doc/BRIEF.md
# Floating-Point Exception Flag Register

This block holds the five sticky exception flags of a floating-point unit and places them on an auxiliary register port at one address. Each cycle the arithmetic datapath may report exceptions as a five-bit pulse vector. Every reported exception is ORed into its flag, and the flag stays set until software changes it.

Software can change the flags in two ways. A write with the write-enable bit (bit 31) set loads bits [4:0] straight into the flags, so it can clear them as well as set them. A write with bit 31 clear leaves bits [4:0] unused. In that case bits [11:7] set individual flags and bit 12 clears all of them, and a set request wins over the clear-all. The enable bit is not stored, so software has to set it again on every direct update. Any code that saves and restores the register must therefore OR bit 31 into the value it restores.

Top module: `fpx_status_reg`

## Requirements
- R1: While reset is asserted, and after it is released, all five flags are zero and a read of the register returns 0x00000000.
- R2: A read at the register address (default 0x301) returns the flags in bits [4:0] and zero in bits [31:5]. The flag order is invalid=0, divide-by-zero=1, overflow=2, underflow=3, inexact=4. A read at any other address returns zero.
- R3: A write with bit 31 set replaces the flags with bits [4:0] of the write data, and this can clear flags.
- R4: A write with bit 31 clear ignores bits [4:0] of the write data.
- R5: A write with bit 31 clear sets flag n when write-data bit 7+n is 1, for n from 0 to 4. Flags whose set bit is 0 keep their value.
- R6: A write with bit 31 clear and bit 12 set clears every flag whose set bit is 0. A set bit in the same write wins over the clear-all.
- R7: When no write occurs, each exception-report bit ORs into its flag on the next clock edge. Flags never clear without a write.
- R8: When an exception report and a write arrive in the same cycle, the new flags equal the result of the write ORed with the reported exceptions.
- R9: A write to any address other than the register address leaves the flags unchanged.
- R10: Bit 31 is never stored. After a write of 0x80000004 the register reads 0x00000004. A following write of 0x00000000 leaves it reading 0x00000004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| aux_addr | input | 12 | Auxiliary register address |
| aux_wr | input | 1 | Write strobe for the current cycle |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data, combinational from the address and the held flags |
| exc_report | input | 5 | One-cycle exception pulses from the datapath, in flag order |

## Verification
A datapath exception report and a software write can fall in the same clock cycle. This case decides whether a freshly raised exception survives a write that clears the flags. The bench sets the exception vector and the write strobe on the same falling edge. It uses a direct write that clears all flags, an indirect clear-all, and a direct write to an unrelated address. It then reads the register one edge later and expects the written result ORed with the reported bits. For the write to the unrelated address, it expects the old flags ORed with the report.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NFLAG   = 5;
  localparam int DATA_W  = 32;
  localparam int WE_BIT  = 31;
  localparam int SET_LSB = 7;
  localparam int CLR_BIT = 12;

  typedef logic [NFLAG-1:0] flags_t;

  typedef struct packed {
    logic   direct;
    logic   indirect;
    logic   clr_all;
    flags_t load_val;
    flags_t set_req;
  } wr_cmd_t;

  function automatic flags_t fpx_next_flags(flags_t cur, wr_cmd_t cmd, flags_t exc);
    flags_t base;
    base = cur;
    if (cmd.direct) base = cmd.load_val;
    else if (cmd.indirect) begin
      if (cmd.clr_all) base = '0;
      base = base | cmd.set_req;
    end
    return base | exc;
  endfunction

  function automatic logic [DATA_W-1:0] fpx_read_word(flags_t f);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NFLAG-1:0] = f;
    return w;
  endfunction
endpackage

// File: rtl/fpx_addr_match.sv
module fpx_addr_match #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h301
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              sel,
  output logic              wr_hit
);
  always_comb begin
    sel    = (addr == REG_ADDR);
    wr_hit = wr && sel;
  end
endmodule

// File: rtl/fpx_wr_decode.sv
module fpx_wr_decode
  import fpx_pkg::*;
(
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output wr_cmd_t           cmd
);
  always_comb begin
    cmd.direct   = wr_hit && wdata[WE_BIT];
    cmd.indirect = wr_hit && !wdata[WE_BIT];
    cmd.clr_all  = wdata[CLR_BIT];
    cmd.load_val = wdata[NFLAG-1:0];
    cmd.set_req  = wdata[SET_LSB +: NFLAG];
  end
endmodule

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank
  import fpx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wr_cmd_t cmd,
  input  flags_t  exc,
  output flags_t  flags
);
  flags_t nxt;
  always_comb nxt = fpx_next_flags(flags, cmd, exc);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= nxt[i];
    end
  end

  // R7: with no write, flags only grow and take every reported bit
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.direct && !cmd.indirect) |=> (flags == ($past(flags) | $past(exc))));
  // R3: a direct write loads the data (plus concurrent exceptions)
  p_direct_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.direct |=> (flags == ($past(cmd.load_val) | $past(exc))));
  // R5, R4: an indirect write without clear-all only adds set bits
  p_indirect_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.indirect && !cmd.clr_all) |=>
      (flags == ($past(flags) | $past(cmd.set_req) | $past(exc))));
  // R6: clear-all leaves only requested sets and exceptions
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.indirect && cmd.clr_all) |=> (flags == ($past(cmd.set_req) | $past(exc))));
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h301
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] aux_addr,
  input  logic              aux_wr,
  input  logic [DATA_W-1:0] aux_wdata,
  output logic [DATA_W-1:0] aux_rdata,
  input  logic [NFLAG-1:0]  exc_report
);
  logic    sel;
  logic    wr_hit;
  wr_cmd_t cmd;
  flags_t  flags;

  fpx_addr_match #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_match (
    .addr(aux_addr), .wr(aux_wr), .sel(sel), .wr_hit(wr_hit));

  fpx_wr_decode i_dec (.wr_hit(wr_hit), .wdata(aux_wdata), .cmd(cmd));

  fpx_flag_bank i_bank (.clk(clk), .rst_n(rst_n), .cmd(cmd),
    .exc(exc_report), .flags(flags));

  always_comb aux_rdata = sel ? fpx_read_word(flags) : '0;

  // R1: reset forces the flags to zero
  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> (flags == '0));
  // R9: a write to another address with no exception keeps the flags
  p_foreign_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_wr && !sel && exc_report == '0) |=> $stable(flags));
  // R10: the enable bit never appears on the read port
  p_no_we_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_rdata[WE_BIT]);
endmodule

// File: tb/test_fpx_status_reg.sv
module test_fpx_status_reg;
  localparam int CLK_P = 10;
  localparam logic [11:0] RA = 12'h301;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] aux_addr = RA;
  logic        aux_wr = 1'b0;
  logic [31:0] aux_wdata = '0;
  logic [31:0] aux_rdata;
  logic [4:0]  exc_report = '0;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  fpx_status_reg i_fpx_status_reg (.clk(clk), .rst_n(rst_n), .aux_addr(aux_addr),
    .aux_wr(aux_wr), .aux_wdata(aux_wdata), .aux_rdata(aux_rdata),
    .exc_report(exc_report));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at the falling edge, result visible at next falling edge
  task automatic cyc(logic wr, logic [11:0] a, logic [31:0] d, logic [4:0] e);
    aux_wr = wr; aux_addr = a; aux_wdata = d; exc_report = e;
    @(negedge clk);
    aux_wr = 1'b0; aux_addr = RA; aux_wdata = '0; exc_report = '0;
  endtask

  task automatic rd(string req, logic [31:0] exp);
    aux_addr = RA; #1; check(req, aux_rdata, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cyc(1'b0, RA, 0, 5'h1f);
    rd("R1", 32'h0);
    rst_n = 1'b1; @(negedge clk);
    rd("R1", 32'h0);
  endtask

  task automatic t_direct;
    cyc(1'b1, RA, 32'h8000_0004, 0); rd("R10", 32'h4);
    cyc(1'b1, RA, 32'h0, 0);         rd("R10", 32'h4);
    cyc(1'b1, RA, 32'h8000_001b, 0); rd("R3", 32'h1b);
    cyc(1'b1, RA, 32'h8000_0000, 0); rd("R3", 32'h0);
  endtask

  task automatic t_ignored_low;
    cyc(1'b1, RA, 32'h0000_001f, 0); rd("R4", 32'h0);
    cyc(1'b1, RA, 32'hffff_e060, 0); rd("R4", 32'h0);
  endtask

  task automatic t_indirect_set;
    cyc(1'b1, RA, 32'h1 << 8, 0);  rd("R5", 32'h2);
    cyc(1'b1, RA, 32'h1 << 11, 0); rd("R5", 32'h12);
    cyc(1'b1, RA, 32'h1 << 12, 0); rd("R6", 32'h0);
    cyc(1'b1, RA, 32'h8000_000f, 0);
    cyc(1'b1, RA, (32'h1 << 12) | (32'h1 << 9), 0); rd("R6", 32'h4);
  endtask

  task automatic t_sticky;
    cyc(1'b1, RA, 32'h8000_0000, 0);
    cyc(1'b0, RA, 0, 5'h01); rd("R7", 32'h01);
    cyc(1'b0, RA, 0, 5'h10); rd("R7", 32'h11);
    cyc(1'b0, RA, 0, 5'h00); rd("R7", 32'h11);
    aux_addr = 12'h300; #1; check("R2", aux_rdata, 32'h0);
    rd("R2", 32'h11);
  endtask

  task automatic t_collide;
    cyc(1'b1, RA, 32'h8000_0000, 5'h08); rd("R8", 32'h08);
    cyc(1'b1, RA, 32'h0000_1000, 5'h02); rd("R8", 32'h02);
    cyc(1'b1, 12'h302, 32'h8000_0000, 5'h04); rd("R8", 32'h06);
  endtask

  task automatic t_foreign;
    cyc(1'b1, 12'h300, 32'h8000_0000, 0); rd("R9", 32'h06);
    cyc(1'b1, 12'h101, 32'h0000_0f80, 0); rd("R9", 32'h06);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_direct();
    t_ignored_low();
    t_indirect_set();
    t_sticky();
    t_collide();
    t_foreign();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule